// File: doc/BRIEF.md
# Speculative Instruction Prefetch Buffer

This block fetches 32-bit instruction words ahead of need over a read-only request/grant/response bus and holds them in a small queue for the decode side. It keeps a fetch address that moves forward by one word for each accepted request. It issues a new request only when a queue slot is sure to be free by the time the response returns. The bus returns responses in issue order and carries no transaction tag. The consumer takes words through a valid/ready handshake, at up to one word per cycle.

A redirect input restarts fetching at a new address, which is first rounded down to a word boundary. On a redirect the queue is emptied. The block records how many reads are still in flight and throws away that many later responses, so no stale word reaches the consumer.

A redirect can arrive while a request is raised but not yet granted. The bus rule does not allow that request to be withdrawn or its address changed. The block therefore keeps it raised in a dedicated state and counts its response as stale once it is granted.

The control is a three-state machine:
- `FS_IDLE` is the reset state. It moves to `FS_RUN` on the first clock edge after reset (the *start* transition).
- `FS_RUN` is normal fetching. It moves to `FS_HOLD` when a redirect meets a raised, ungranted request (the *redirect_blocked* transition).
- `FS_HOLD` keeps the old request raised. It returns to `FS_RUN` when that request is granted (the *stale_granted* transition). A further redirect in `FS_HOLD` only replaces the target address.

Top module: `ipf_prefetch`

## Requirements
- R1: Every address presented with a raised request has bits [1:0] equal to zero. A redirect target is used with its two low bits cleared.
- R2: Once raised, the request stays high, with an unchanged address, until a cycle in which grant is high.
- R3: After each grant in `FS_RUN`, the fetch address advances by 4. The consumer receives the data of consecutive word addresses, starting at the reset address (default 0) or at the latest rounded redirect target.
- R4: A request is raised only while the queue occupancy plus the outstanding reads, minus the word leaving in the same cycle, is below DEPTH (default 2).
- R5: A response that is kept is written to the queue. Output valid is high exactly when the queue holds a word and no redirect is present in that cycle, so a kept word is first offered in the cycle after its response.
- R6: A redirect empties the queue. Output valid is low in the redirect cycle and in the cycle after it.
- R7: Responses to all reads granted before a redirect are discarded. This includes a held request granted later in `FS_HOLD`.
- R8: With grant high on every request, a response latency of one cycle and the consumer always ready, the consumer receives one word in every cycle once fetching has settled.
- R9: While output valid is high and ready is low without a redirect, the next cycle presents the same word.
- R10: During reset, request and output valid are low. The first request after reset uses the reset address.
- R11: A redirect that meets a raised, ungranted request enters `FS_HOLD`. The old address stays on the bus until it is granted, and fetching then resumes at the new target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| redirect_i | input | 1 | Restart fetching at redirect_addr_i |
| redirect_addr_i | input | AW | New fetch address (rounded down to a word) |
| bus_req_o | output | 1 | Read request valid |
| bus_addr_o | output | AW | Word-aligned read address |
| bus_gnt_i | input | 1 | Request accepted in this cycle |
| bus_rvalid_i | input | 1 | Read data valid, one pulse per granted request |
| bus_rdata_i | input | DW | Read data |
| out_valid_o | output | 1 | A fetched word is offered |
| out_ready_i | input | 1 | Consumer takes the offered word |
| out_word_o | output | DW | Offered instruction word |

## Verification
The assertions assume a well-behaved bus on the input side:
- grant is high only while the request is high;
- each grant is answered by exactly one read-valid pulse, at least one cycle later and in issue order;
- no read-valid pulse arrives without an outstanding grant.

The bench keeps within these rules by design of its responder. It raises grant only after sampling a high request. It stores each granted address in a queue. It returns the entries strictly from the front, each due cycle being later than the previous one, after delays drawn from one to several cycles.

// File: rtl/ipf_pkg.sv
`timescale 1ns/1ps
package ipf_pkg;

    // Control states of the fetch sequencer
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,   // reset state, no request
        FS_RUN  = 2'd1,   // normal speculative fetching
        FS_HOLD = 2'd2    // stale request held until its grant
    } fetch_state_e;

    localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/ipf_fifo.sv
`timescale 1ns/1ps
module ipf_fifo #(
    parameter int unsigned DEPTH = 2,
    parameter int unsigned DW    = 32
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          flush_i,
    input  logic                          push_i,
    input  logic [DW-1:0]                 wdata_i,
    input  logic                          pop_i,
    output logic [DW-1:0]                 rdata_o,
    output logic                          empty_o,
    output logic [$clog2(DEPTH+1)-1:0]    count_o
);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] slot_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else if (flush_i) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) wr_q <= bump(wr_q);
            if (pop_i)  rd_q <= bump(rd_q);
            cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
        end
    end

    // One storage register per slot, written when the write pointer selects it
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk_i) begin
            if (push_i && !flush_i && (wr_q == PW'(i))) begin
                slot_q[i] <= wdata_i;
            end
        end
    end

    assign rdata_o = slot_q[rd_q];
    assign empty_o = (cnt_q == '0);
    assign count_o = cnt_q;

endmodule

// File: rtl/ipf_credit.sv
`timescale 1ns/1ps
module ipf_credit #(
    parameter int unsigned DEPTH = 2
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       grant_i,
    input  logic                       stale_grant_i,
    input  logic                       rvalid_i,
    input  logic                       redirect_i,
    output logic [$clog2(DEPTH+1)-1:0] outst_o,
    output logic                       accept_o
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [CW-1:0] outst_q, outst_d;
    logic [CW-1:0] drop_q, drop_d;
    logic          drop_hit;

    // Reads in flight after this cycle
    assign outst_d  = outst_q + CW'(grant_i) - CW'(rvalid_i);
    assign drop_hit = rvalid_i && (drop_q != '0);

    always_comb begin
        if (redirect_i) begin
            // everything still in flight belongs to the old stream
            drop_d = outst_d;
        end else begin
            drop_d = drop_q + CW'(stale_grant_i) - CW'(drop_hit);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            outst_q <= '0;
            drop_q  <= '0;
        end else begin
            outst_q <= outst_d;
            drop_q  <= drop_d;
        end
    end

    assign accept_o = rvalid_i && (drop_q == '0) && !redirect_i;
    assign outst_o  = outst_q;

endmodule

// File: rtl/ipf_fetch_fsm.sv
`timescale 1ns/1ps
module ipf_fetch_fsm
    import ipf_pkg::*;
#(
    parameter int unsigned    AW         = 32,
    parameter logic [AW-1:0]  RESET_ADDR = '0
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          credit_ok_i,
    input  logic          gnt_i,
    input  logic          redirect_i,
    input  logic [AW-1:0] redirect_addr_i,
    output logic          req_o,
    output logic [AW-1:0] addr_o,
    output logic          grant_o,
    output logic          stale_grant_o
);
    localparam logic [AW-1:0] WORD_MASK = ~AW'(WORD_BYTES - 1);
    localparam logic [AW-1:0] STEP      = AW'(WORD_BYTES);

    fetch_state_e  state_q, state_d;
    logic [AW-1:0] fetch_q, held_q;
    logic [AW-1:0] target;
    logic          blocked;

    assign target  = redirect_addr_i & WORD_MASK;
    assign blocked = redirect_i && req_o && !gnt_i;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= FS_IDLE;
        else         state_q <= state_d;
    end

    // Transitions: start, redirect_blocked, stale_granted
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE: state_d = FS_RUN;
            FS_RUN:  if (blocked) state_d = FS_HOLD;
            FS_HOLD: if (gnt_i)   state_d = FS_RUN;
            default: state_d = FS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            FS_IDLE: begin
                req_o  = 1'b0;
                addr_o = fetch_q;
            end
            FS_RUN: begin
                req_o  = credit_ok_i;
                addr_o = fetch_q;
            end
            FS_HOLD: begin
                req_o  = 1'b1;
                addr_o = held_q;
            end
            default: begin
                req_o  = 1'b0;
                addr_o = fetch_q;
            end
        endcase
    end

    assign grant_o       = req_o && gnt_i;
    assign stale_grant_o = grant_o && (state_q == FS_HOLD);

    // Fetch and held addresses
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fetch_q <= RESET_ADDR & WORD_MASK;
            held_q  <= RESET_ADDR & WORD_MASK;
        end else begin
            if (redirect_i) begin
                fetch_q <= target;
                if (state_q == FS_RUN && blocked) held_q <= fetch_q;
            end else if (grant_o && state_q == FS_RUN) begin
                fetch_q <= fetch_q + STEP;
            end
        end
    end

endmodule

// File: rtl/ipf_prefetch.sv
`timescale 1ns/1ps
module ipf_prefetch
    import ipf_pkg::*;
#(
    parameter int unsigned    DEPTH      = 2,
    parameter int unsigned    AW         = 32,
    parameter int unsigned    DW         = 32,
    parameter logic [AW-1:0]  RESET_ADDR = '0
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          redirect_i,
    input  logic [AW-1:0] redirect_addr_i,
    output logic          bus_req_o,
    output logic [AW-1:0] bus_addr_o,
    input  logic          bus_gnt_i,
    input  logic          bus_rvalid_i,
    input  logic [DW-1:0] bus_rdata_i,
    output logic          out_valid_o,
    input  logic          out_ready_i,
    output logic [DW-1:0] out_word_o
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [CW-1:0] fifo_count;
    logic [CW-1:0] outst_count;
    logic          fifo_empty;
    logic          pop;
    logic          accept;
    logic          grant;
    logic          stale_grant;
    logic          credit_ok;
    logic [CW:0]   load;

    assign out_valid_o = !fifo_empty && !redirect_i;
    assign pop         = out_valid_o && out_ready_i;

    // Slots committed after this cycle's departure, before any new grant
    assign load      = {1'b0, fifo_count} + {1'b0, outst_count} - {{CW{1'b0}}, pop};
    assign credit_ok = (load < (CW+1)'(DEPTH));

    ipf_fetch_fsm #(
        .AW         (AW),
        .RESET_ADDR (RESET_ADDR)
    ) u_fsm (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .credit_ok_i     (credit_ok),
        .gnt_i           (bus_gnt_i),
        .redirect_i      (redirect_i),
        .redirect_addr_i (redirect_addr_i),
        .req_o           (bus_req_o),
        .addr_o          (bus_addr_o),
        .grant_o         (grant),
        .stale_grant_o   (stale_grant)
    );

    ipf_credit #(
        .DEPTH (DEPTH)
    ) u_credit (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .grant_i       (grant),
        .stale_grant_i (stale_grant),
        .rvalid_i      (bus_rvalid_i),
        .redirect_i    (redirect_i),
        .outst_o       (outst_count),
        .accept_o      (accept)
    );

    ipf_fifo #(
        .DEPTH (DEPTH),
        .DW    (DW)
    ) u_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .flush_i (redirect_i),
        .push_i  (accept),
        .wdata_i (bus_rdata_i),
        .pop_i   (pop),
        .rdata_o (out_word_o),
        .empty_o (fifo_empty),
        .count_o (fifo_count)
    );

endmodule

// File: rtl/ipf_prefetch_chk.sv
`timescale 1ns/1ps
module ipf_prefetch_chk #(
    parameter int unsigned DEPTH = 2,
    parameter int unsigned AW    = 32,
    parameter int unsigned DW    = 32
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic                       redirect_i,
    input logic                       bus_req_o,
    input logic [AW-1:0]              bus_addr_o,
    input logic                       bus_gnt_i,
    input logic                       out_valid_o,
    input logic                       out_ready_i,
    input logic [DW-1:0]              out_word_o,
    input logic [$clog2(DEPTH+1)-1:0] occ_i,
    input logic [$clog2(DEPTH+1)-1:0] outst_i
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    assert_reset_quiet_R10: assert property (@(posedge clk_i)
        !rst_ni |-> (!bus_req_o && !out_valid_o));

    assert_addr_aligned_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_req_o |-> (bus_addr_o[1:0] == 2'b00));

    assert_req_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_o && !bus_gnt_i) |=> bus_req_o);

    assert_addr_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_o && !bus_gnt_i) |=> $stable(bus_addr_o));

    assert_slot_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ({1'b0, occ_i} + {1'b0, outst_i}) <= (CW+1)'(DEPTH));

    assert_flush_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_i |=> !out_valid_o);

    assert_word_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_ready_i && !redirect_i) |=> $stable(out_word_o));

    assert_valid_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_ready_i && !redirect_i) |=> (out_valid_o || redirect_i));

endmodule

bind ipf_prefetch ipf_prefetch_chk #(
    .DEPTH (DEPTH),
    .AW    (AW),
    .DW    (DW)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .redirect_i  (redirect_i),
    .bus_req_o   (bus_req_o),
    .bus_addr_o  (bus_addr_o),
    .bus_gnt_i   (bus_gnt_i),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_word_o  (out_word_o),
    .occ_i       (fifo_count),
    .outst_i     (outst_count)
);

// File: tb/ipf_prefetch_test.sv
`timescale 1ns/1ps
module ipf_prefetch_test;
    localparam int DEPTH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redirect = 1'b0;
    logic [31:0] redirect_addr = '0;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic        bus_gnt = 1'b0;
    logic        bus_rvalid = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_word;

    always #2 clk = ~clk;

    ipf_prefetch #(.DEPTH(DEPTH)) uut (
        .clk_i(clk), .rst_ni(rst_n),
        .redirect_i(redirect), .redirect_addr_i(redirect_addr),
        .bus_req_o(bus_req), .bus_addr_o(bus_addr), .bus_gnt_i(bus_gnt),
        .bus_rvalid_i(bus_rvalid), .bus_rdata_i(bus_rdata),
        .out_valid_o(out_valid), .out_ready_i(out_ready), .out_word_o(out_word)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    int cyc      = 0;
    logic [31:0] lfsr = 32'h1234_5678;
    int gnt_pct = 100;
    int lat_max = 1;

    logic [31:0] rq_addr[$];
    int          rq_due[$];
    int          last_due = 0;

    // behavioural reference state
    int          outst_m = 0;
    int          drop_m  = 0;
    int          occ_m   = 0;
    bit          hold_m  = 1'b0;
    logic [31:0] exp_pc  = '0;
    bit          prev_wait = 1'b0;
    bit          prev_blocked = 1'b0;
    logic [31:0] prev_addr = '0;
    bit          prev_stall = 1'b0;
    logic [31:0] prev_word = '0;
    bit          seen_first = 1'b0;
    int          hs_count = 0;

    function automatic logic [31:0] memval(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic int rnd100();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return int'(lfsr % 100);
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input bit rdy, input bit redir, input logic [31:0] tgt);
        logic g;
        logic rv;
        logic pop;
        int   extra;
        int   due;
        @(negedge clk);
        out_ready     = rdy;
        redirect      = redir;
        redirect_addr = tgt;
        if (rq_addr.size() > 0 && rq_due[0] <= cyc) begin
            bus_rvalid = 1'b1;
            bus_rdata  = memval(rq_addr.pop_front());
            void'(rq_due.pop_front());
        end else begin
            bus_rvalid = 1'b0;
            bus_rdata  = 32'h0;
        end
        rv = bus_rvalid;
        #1;
        g = bus_req && (gnt_pct >= 100 || rnd100() < gnt_pct);
        bus_gnt = g;
        pop = out_valid && rdy;

        if (bus_req)
            check(bus_addr[1:0] == 2'b00, "R1 address alignment", bus_addr, bus_addr & ~32'h3);
        if (prev_wait) begin
            check(bus_req == 1'b1, "R2 request held until grant", {31'b0, bus_req}, 32'd1);
            check(bus_addr == prev_addr, "R2 address stable until grant", bus_addr, prev_addr);
        end
        if (prev_blocked)
            check(bus_req && bus_addr == prev_addr, "R11 old request kept after redirect", bus_addr, prev_addr);
        if (bus_req && !seen_first) begin
            check(bus_addr == 32'h0, "R10 first request at reset address", bus_addr, 32'h0);
            seen_first = 1'b1;
        end
        check(out_valid == (occ_m > 0 && !redir), "R5 R6 output valid",
              {31'b0, out_valid}, {31'b0, (occ_m > 0 && !redir)});
        if (prev_stall)
            check(out_word == prev_word, "R9 word held while stalled", out_word, prev_word);
        if (pop) begin
            check(out_word == memval(exp_pc), "R3 R7 word sequence", out_word, memval(exp_pc));
            exp_pc += 32'd4;
            hs_count++;
        end
        if (!prev_wait && (occ_m + outst_m - int'(pop)) >= DEPTH)
            check(!bus_req, "R4 no request without a free slot", {31'b0, bus_req}, 32'd0);

        // reference update
        if (g) begin
            extra = (lat_max > 1) ? (rnd100() % lat_max) : 0;
            due = cyc + 1 + extra;
            if (due <= last_due) due = last_due + 1;
            last_due = due;
            rq_addr.push_back(bus_addr);
            rq_due.push_back(due);
        end
        if (redir) begin
            drop_m = outst_m + int'(g) - int'(rv);
            occ_m  = 0;
            hold_m = bus_req && !g;
            exp_pc = tgt & ~32'h3;
        end else begin
            if (rv) begin
                if (drop_m > 0) drop_m--;
                else            occ_m++;
            end
            if (g && hold_m) begin
                drop_m++;
                hold_m = 1'b0;
            end
            occ_m -= int'(pop);
        end
        outst_m += int'(g) - int'(rv);
        prev_blocked = redir && bus_req && !g;
        prev_wait    = bus_req && !g;
        prev_addr    = bus_addr;
        prev_stall   = out_valid && !rdy;
        prev_word    = out_word;
        cyc++;
    endtask

    initial begin
        int hs_before;
        // reset state (R10)
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!bus_req, "R10 request low in reset", {31'b0, bus_req}, 32'd0);
            check(!out_valid, "R10 valid low in reset", {31'b0, out_valid}, 32'd0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R8: full-rate streaming
        gnt_pct = 100; lat_max = 1;
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 32'h0);
        hs_before = hs_count;
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 32'h0);
        check(hs_count - hs_before == 40, "R8 one word per cycle",
              32'(hs_count - hs_before), 32'd40);

        // mixed stalls, latencies and redirects (R3 R6 R7)
        gnt_pct = 60; lat_max = 4;
        for (int i = 0; i < 600; i++) begin
            bit r;
            r = (rnd100() < 70);
            step(r, (i % 41) == 40, 32'h0000_1000 + 32'(i * 6) + 32'd1);
        end

        // R11: redirects while a request waits for grant
        gnt_pct = 0; lat_max = 1;
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 32'h0);
        step(1'b1, 1'b1, 32'h0000_2002);
        step(1'b1, 1'b1, 32'h0000_3007);
        step(1'b1, 1'b0, 32'h0);
        gnt_pct = 100;
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 32'h0);

        // R4 and R9: consumer stalls until the queue fills
        for (int i = 0; i < 15; i++) step(1'b0, 1'b0, 32'h0);
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 32'h0);

        // long latency with a redirect mid-flight (R7)
        lat_max = 6;
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 32'h0);
        step(1'b1, 1'b1, 32'h0000_8003);
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 32'h0);
        lat_max = 1;
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule